// File: doc/BRIEF.md
# Dual Add/Subtract Accumulator for Complex Data

This block holds two 20-bit adder/subtractor lanes, one for the real part and one for the imaginary part. Both lanes share a pair of registered 16-bit signed operand inputs, A and B. Each lane has its own 2-bit operation code that selects add, subtract, reverse subtract or pass. In front of each lane, a multiplexer feeds the lane's first operand from either new A data or the lane's own accumulator. This lets the block perform complex conjugation, radix-2 butterflies, or complex accumulation for filters.

A deskew line holds the registered A operand for 8 cycles. When the delay select is set, the real lane uses that delayed copy as its new-data operand. This keeps data that skipped a multiplier stage in phase with data that went through it.

All controls are captured in a control register before they act. The inputs on which all of this depends are:

- the operation codes,
- the common clear,
- the common feedback select,
- the delay select,
- the A and B values loaded under their active-low enables.

Values present at clock edge k therefore appear on the results after edge k+1.

Top module: `cplx_addsub_acc`

## Requirements
- R1: While rst_n is low, res_re and res_im are zero and ovf is low.
- R2: Each lane applies its own code: 2'b00 gives X+B, 2'b01 gives X-B, 2'b10 gives B-X and 2'b11 gives X. X is the lane's first operand. With feedback select low, X is the registered A.
- R3: ovf is high in a cycle exactly when either lane's 20-bit two's-complement result for that cycle wrapped. The result holds the low 20 bits. ovf is never high when feedback select was low for that result.
- R4: With fb_sel high, a lane's first operand is its own current accumulator, so repeated cycles accumulate.
- R5: With acc_clr high, both accumulators load zero and ovf is low, whatever the operation codes are.
- R6: op_re, op_im, acc_clr, fb_sel and dly_sel are registered. Values present at edge k govern the result that appears after edge k+1.
- R7: The A register loads only at edges where cea_n is low. The B register loads only at edges where ceb_n is low. Otherwise each register keeps its value.
- R8: With dly_sel high and fb_sel low, the real lane's first operand is the registered A value from 8 cycles before the value the imaginary lane uses. The imaginary lane never uses the delayed value.
- R9: The 16-bit operands are treated as signed and sign-extended to 20 bits before the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 16 | Signed operand A |
| b_in | input | 16 | Signed operand B |
| cea_n | input | 1 | Active-low load enable of the A register |
| ceb_n | input | 1 | Active-low load enable of the B register |
| op_re | input | 2 | Real-lane operation code |
| op_im | input | 2 | Imaginary-lane operation code |
| acc_clr | input | 1 | Clears both accumulators |
| fb_sel | input | 1 | Selects accumulator feedback for both lanes |
| dly_sel | input | 1 | Selects the 8-cycle delayed A for the real lane |
| res_re | output | 20 | Real-lane result |
| res_im | output | 20 | Imaginary-lane result |
| ovf | output | 1 | Either lane wrapped in this result |

## Verification
The bench drives eight kinds of stimulus:

- **All four codes on differing lanes.** Separates operand order and sign handling.
- **Negative extremes.** Expose a missing sign extension.
- **Long feedback runs with large B.** Distinguish accumulation from plain addition and reach the wrap point where ovf must rise.
- **Clear in the middle of a feedback run.** Shows that clear wins over the operation code.
- **Held enables.** Show that the A and B registers keep their values.
- **A ramp under delay select.** Tells an 8-cycle offset apart from 7 or 9.
- **Delay select on the imaginary lane.** The same ramp shows that lane ignores the delay.
- **A random mix of all controls.** Catches controls acting one cycle early or late.

// File: rtl/cas_pkg.sv
package cas_pkg;
   typedef enum logic [1:0] {
      OP_ADD   = 2'b00,
      OP_SUB   = 2'b01,
      OP_RSUB  = 2'b10,
      OP_PASS  = 2'b11
   } cas_op_e;

   typedef struct packed {
      cas_op_e op_re;
      cas_op_e op_im;
      logic    clr;
      logic    fb;
      logic    dly;
   } cas_ctl_t;
endpackage

// File: rtl/cas_deskew.sv
module cas_deskew #(
   parameter int W     = 16,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("cas_deskew: DEPTH must be at least 1");
   end

   logic [W-1:0] stage [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[0] <= '0;
            else        stage[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[i] <= '0;
            else        stage[i] <= stage[i-1];
         end
      end
   end

   assign dout = stage[DEPTH-1];
endmodule

// File: rtl/cas_lane.sv
module cas_lane
   import cas_pkg::*;
#(
   parameter int IN_W  = 16,
   parameter int ACC_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cas_op_e          op,
   input  logic             clr,
   input  logic             fb,
   input  logic [ACC_W-1:0] x_new,
   input  logic [IN_W-1:0]  b_raw,
   output logic [ACC_W-1:0] acc,
   output logic             ovf
);
   localparam int EXT_W = ACC_W - IN_W;
   localparam int WIDE  = ACC_W + 1;

   logic [ACC_W-1:0] x_op, y_op;
   logic [WIDE-1:0]  x_w, y_w, sum_w;
   logic             wrap;

   assign y_op = {{EXT_W{b_raw[IN_W-1]}}, b_raw};
   assign x_op = fb ? acc : x_new;
   assign x_w  = {x_op[ACC_W-1], x_op};
   assign y_w  = {y_op[ACC_W-1], y_op};

   always_comb begin
      unique case (op)
         OP_ADD:  sum_w = x_w + y_w;
         OP_SUB:  sum_w = x_w - y_w;
         OP_RSUB: sum_w = y_w - x_w;
         default: sum_w = x_w;
      endcase
   end

   assign wrap = sum_w[WIDE-1] ^ sum_w[WIDE-2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         ovf <= 1'b0;
      end else if (clr) begin
         acc <= '0;
         ovf <= 1'b0;
      end else begin
         acc <= sum_w[ACC_W-1:0];
         ovf <= wrap;
      end
   end
endmodule

// File: rtl/cplx_addsub_acc.sv
module cplx_addsub_acc
   import cas_pkg::*;
#(
   parameter int IN_W      = 16,
   parameter int ACC_W     = 20,
   parameter int DLY_DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IN_W-1:0]  a_in,
   input  logic [IN_W-1:0]  b_in,
   input  logic             cea_n,
   input  logic             ceb_n,
   input  logic [1:0]       op_re,
   input  logic [1:0]       op_im,
   input  logic             acc_clr,
   input  logic             fb_sel,
   input  logic             dly_sel,
   output logic [ACC_W-1:0] res_re,
   output logic [ACC_W-1:0] res_im,
   output logic             ovf
);
   localparam int EXT_W = ACC_W - IN_W;

   if (ACC_W <= IN_W) begin : g_bad_width
      $error("cplx_addsub_acc: ACC_W must exceed IN_W");
   end

   logic [IN_W-1:0]  a_q, b_q, a_dly;
   logic [ACC_W-1:0] x_re, x_im;
   logic             ovf_re, ovf_im;
   cas_ctl_t         ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q   <= '0;
         b_q   <= '0;
         ctl_q <= '0;
      end else begin
         if (!cea_n) a_q <= a_in;
         if (!ceb_n) b_q <= b_in;
         ctl_q.op_re <= cas_op_e'(op_re);
         ctl_q.op_im <= cas_op_e'(op_im);
         ctl_q.clr   <= acc_clr;
         ctl_q.fb    <= fb_sel;
         ctl_q.dly   <= dly_sel;
      end
   end

   cas_deskew #(.W(IN_W), .DEPTH(DLY_DEPTH)) u_deskew (
      .clk(clk), .rst_n(rst_n), .din(a_q), .dout(a_dly)
   );

   assign x_re = ctl_q.dly ? {{EXT_W{a_dly[IN_W-1]}}, a_dly}
                           : {{EXT_W{a_q[IN_W-1]}}, a_q};
   assign x_im = {{EXT_W{a_q[IN_W-1]}}, a_q};

   cas_lane #(.IN_W(IN_W), .ACC_W(ACC_W)) u_lane_re (
      .clk(clk), .rst_n(rst_n), .op(ctl_q.op_re), .clr(ctl_q.clr),
      .fb(ctl_q.fb), .x_new(x_re), .b_raw(b_q), .acc(res_re), .ovf(ovf_re)
   );

   cas_lane #(.IN_W(IN_W), .ACC_W(ACC_W)) u_lane_im (
      .clk(clk), .rst_n(rst_n), .op(ctl_q.op_im), .clr(ctl_q.clr),
      .fb(ctl_q.fb), .x_new(x_im), .b_raw(b_q), .acc(res_im), .ovf(ovf_im)
   );

   assign ovf = ovf_re | ovf_im;
endmodule

// File: rtl/cas_checker.sv
module cas_checker #(
   parameter int IN_W  = 16,
   parameter int ACC_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IN_W-1:0]  a_in,
   input logic [IN_W-1:0]  b_in,
   input logic             cea_n,
   input logic             ceb_n,
   input logic [1:0]       op_im,
   input logic             acc_clr,
   input logic             fb_sel,
   input logic [ACC_W-1:0] res_re,
   input logic [ACC_W-1:0] res_im,
   input logic             ovf
);
   localparam int EXT_W = ACC_W - IN_W;

   logic [1:0] cyc;
   logic       cyc_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cyc <= '0;
      else if (cyc != 3) cyc <= cyc + 2'd1;
   end
   assign cyc_ok = (cyc >= 2);

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_R1: assert (res_re == '0 && res_im == '0 && !ovf);
      end
   end

   assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_ok && $past(acc_clr, 2)) |-> (res_re == '0 && res_im == '0 && !ovf));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_ok && !$past(fb_sel, 2)) |-> !ovf);

   assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_ok && $past(op_im == 2'b11 && !fb_sel && !acc_clr && !cea_n, 2))
      |-> (res_im == {{EXT_W{$past(a_in[IN_W-1], 2)}}, $past(a_in, 2)}));

   assert_add_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_ok && $past(op_im == 2'b00 && !fb_sel && !acc_clr && !cea_n && !ceb_n, 2))
      |-> (res_im == ({{EXT_W{$past(a_in[IN_W-1], 2)}}, $past(a_in, 2)}
                    + {{EXT_W{$past(b_in[IN_W-1], 2)}}, $past(b_in, 2)})));
endmodule

bind cplx_addsub_acc cas_checker #(.IN_W(IN_W), .ACC_W(ACC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .cea_n(cea_n),
   .ceb_n(ceb_n), .op_im(op_im), .acc_clr(acc_clr), .fb_sel(fb_sel),
   .res_re(res_re), .res_im(res_im), .ovf(ovf)
);

// File: tb/cplx_addsub_acc_tb.sv
`timescale 1ns/1ps
module cplx_addsub_acc_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] a_in = '0, b_in = '0;
   logic        cea_n = 1'b0, ceb_n = 1'b0;
   logic [1:0]  op_re = '0, op_im = '0;
   logic        acc_clr = 1'b0, fb_sel = 1'b0, dly_sel = 1'b0;
   logic [19:0] res_re, res_im;
   logic        ovf;

   int    n_checks = 0;
   int    n_errors = 0;
   string tag = "R1";
   bit    done = 1'b0;

   always #2.5 clk = ~clk;

   cplx_addsub_acc u_dut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .cea_n(cea_n),
      .ceb_n(ceb_n), .op_re(op_re), .op_im(op_im), .acc_clr(acc_clr),
      .fb_sel(fb_sel), .dly_sel(dly_sel), .res_re(res_re), .res_im(res_im),
      .ovf(ovf)
   );

   // reference model state
   logic [15:0] m_a, m_b;
   logic [1:0]  m_opr, m_opi;
   logic        m_clr, m_fb, m_dly, m_ovf;
   int          m_accr, m_acci;
   logic [15:0] hist[$];

   function automatic int sx16(input logic [15:0] v);
      logic signed [15:0] s;
      s = v;
      return s;
   endfunction

   task automatic lane(input logic [1:0] op, input int x, input int y,
                       input logic clr, output int acc, output logic ov);
      int r;
      logic signed [19:0] t;
      case (op)
         2'd0: r = x + y;
         2'd1: r = x - y;
         2'd2: r = y - x;
         default: r = x;
      endcase
      if (clr) begin
         acc = 0; ov = 1'b0;
      end else begin
         ov  = (r > 524287) || (r < -524288);
         t   = r[19:0];
         acc = t;
      end
   endtask

   always @(posedge clk or negedge rst_n) begin : model
      int xr, xi, yb, nr, ni;
      logic ovr, ovi;
      if (!rst_n) begin
         m_a = '0; m_b = '0; m_opr = '0; m_opi = '0;
         m_clr = 0; m_fb = 0; m_dly = 0; m_ovf = 0;
         m_accr = 0; m_acci = 0;
         hist = {};
         repeat (8) hist.push_back(16'h0);
      end else begin
         yb = sx16(m_b);
         xr = m_fb ? m_accr : (m_dly ? sx16(hist[0]) : sx16(m_a));
         xi = m_fb ? m_acci : sx16(m_a);
         lane(m_opr, xr, yb, m_clr, nr, ovr);
         lane(m_opi, xi, yb, m_clr, ni, ovi);
         m_accr = nr; m_acci = ni; m_ovf = ovr | ovi;
         hist.push_back(m_a);
         void'(hist.pop_front());
         if (!cea_n) m_a = a_in;
         if (!ceb_n) m_b = b_in;
         m_opr = op_re; m_opi = op_im;
         m_clr = acc_clr; m_fb = fb_sel; m_dly = dly_sel;
      end
   end

   task automatic chk(input string name, input logic [19:0] act, input logic [19:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, name, act, exp);
      end
   endtask

   task automatic compare();
      chk("res_re", res_re, m_accr[19:0]);
      chk("res_im", res_im, m_acci[19:0]);
      chk("ovf", {19'd0, ovf}, {19'd0, m_ovf});
   endtask

   task automatic step(input logic [15:0] a, input logic [15:0] b,
                       input logic ca, input logic cb,
                       input logic [1:0] opr, input logic [1:0] opi,
                       input logic clr, input logic fb, input logic dly);
      a_in = a; b_in = b; cea_n = ca; ceb_n = cb;
      op_re = opr; op_im = opi; acc_clr = clr; fb_sel = fb; dly_sel = dly;
      @(negedge clk);
      compare();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_errors++; n_checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state, driving busy inputs that must not matter
      a_in = 16'h1234; b_in = 16'h4321; fb_sel = 1'b1;
      repeat (3) begin
         @(negedge clk);
         tag = "R1";
         compare();
      end
      a_in = '0; b_in = '0; fb_sel = 1'b0;
      rst_n = 1'b1;

      // R2: every code on both lanes, plain data
      tag = "R2";
      for (int op = 0; op < 4; op++) begin
         step(16'd1000, 16'd300, 0, 0, op[1:0], 2'(3 - op), 0, 0, 0);
         step(16'd77, 16'd5000, 0, 0, op[1:0], 2'(op + 1), 0, 0, 0);
      end

      // R9: negative and extreme operands
      tag = "R9";
      step(16'h8000, 16'h8000, 0, 0, 2'd0, 2'd1, 0, 0, 0);
      step(16'h8000, 16'h7FFF, 0, 0, 2'd1, 2'd2, 0, 0, 0);
      step(16'hFFFF, 16'h0001, 0, 0, 2'd3, 2'd0, 0, 0, 0);
      step(16'h7FFF, 16'h8000, 0, 0, 2'd2, 2'd1, 0, 0, 0);

      // R4: accumulation through feedback
      tag = "R4";
      step(16'd10, 16'd100, 0, 0, 2'd0, 2'd1, 1, 0, 0);
      repeat (10) step(16'd10, 16'd100, 0, 0, 2'd0, 2'd1, 0, 1, 0);

      // R3: drive accumulators past the 20-bit limit
      tag = "R3";
      step(16'd0, 16'h7FFF, 0, 0, 2'd0, 2'd2, 1, 0, 0);
      repeat (24) step(16'd0, 16'h7FFF, 0, 0, 2'd0, 2'd1, 0, 1, 0);
      repeat (24) step(16'd0, 16'h8000, 0, 0, 2'd0, 2'd2, 0, 1, 0);

      // R5: clear wins over any code during accumulation
      tag = "R5";
      step(16'd5, 16'd5, 0, 0, 2'd0, 2'd0, 1, 1, 0);
      step(16'd5, 16'd5, 0, 0, 2'd2, 2'd3, 1, 1, 1);
      step(16'd5, 16'd5, 0, 0, 2'd0, 2'd0, 0, 1, 0);
      step(16'd5, 16'd5, 0, 0, 2'd0, 2'd0, 0, 1, 0);

      // R7: held enables keep old operands
      tag = "R7";
      step(16'd111, 16'd222, 0, 0, 2'd0, 2'd1, 0, 0, 0);
      step(16'd999, 16'd888, 1, 0, 2'd0, 2'd1, 0, 0, 0);
      step(16'd555, 16'd444, 0, 1, 2'd0, 2'd1, 0, 0, 0);
      step(16'd333, 16'd666, 1, 1, 2'd0, 2'd1, 0, 0, 0);
      step(16'd1, 16'd2, 1, 1, 2'd3, 2'd2, 0, 0, 0);

      // R8: deskew on the real lane only
      tag = "R8";
      for (int i = 0; i < 24; i++)
         step(16'(i * 37 + 1), 16'd3, 0, 0, 2'd3, 2'd3, 0, 0, 1);
      for (int i = 0; i < 12; i++)
         step(16'(16'hF000 + i), 16'd9, 0, 0, 2'd0, 2'd1, 0, 0, i[1]);

      // R6: random mix of all controls, compared every cycle
      tag = "R6";
      for (int i = 0; i < 400; i++) begin
         logic [31:0] r;
         r = $urandom;
         step(16'($urandom), 16'($urandom), r[0] & r[1], r[2] & r[3],
              r[5:4], r[7:6], (r[15:11] == 0), r[8] | r[9], r[10]);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule